// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes into an asynchronous serial stream on a single output line. The character shape comes from static configuration inputs: five to eight data bits, an optional parity bit of odd or even sense, and a stop length of one, one and a half, or two bit times. Bit timing comes from a 16-bit divisor that drives a baud generator. The generator emits one tick every `divisor` clock cycles, and every bit lasts sixteen ticks.

Software-style byte writes set up the block. With the divisor-select input high, address 0 loads the divisor's low byte and address 1 loads its high byte. With divisor-select low, address 0 writes the 8-bit holding register. The transmitter moves the held byte into its shift register on a tick and starts the frame. It reports when the holding register can take another byte and when the whole transmitter has gone quiet. The configuration is captured when each frame starts, so changing it during a frame only affects later frames.

Top module: `async_tx`

## Requirements
- R1: A frame is one low start bit, then the data bits least significant first, then the parity bit when enabled, then high stop bits. The line sits high when no frame is being sent.
- R2: `cfg_len` selects the character length as 5 + `cfg_len` (0→5, 1→6, 2→7, 3→8). Holding-register bits above the selected length are not sent.
- R3: With `cfg_par_en` = 1 a parity bit follows the data. It is computed over the sent data bits only. `cfg_par_odd` = 0 makes the count of ones in data plus parity even, and `cfg_par_odd` = 1 makes it odd.
- R4: With `cfg_stop_long` = 0 the frame ends with one stop bit (16 ticks). With `cfg_stop_long` = 1 it ends with two stop bits (32 ticks), except at five data bits, where it ends with one and a half stop bits (24 ticks).
- R5: Every start, data and parity bit lasts 16 ticks, and a tick occurs every `divisor` clock cycles. A divisor of 0 behaves as 1. A whole frame therefore spans (16·(1+n+p) + stop ticks)·divisor cycles, measured from the start-bit edge.
- R6: A write with `div_sel` = 1 loads the divisor's low byte at `wr_addr` = 0 and its high byte at `wr_addr` = 1. The divisor is 1 after reset.
- R7: A write with `div_sel` = 0 and `wr_addr` = 0 loads the holding register, and `hold_empty` is low from the next cycle. A write with `div_sel` = 0 and `wr_addr` = 1 changes nothing.
- R8: `hold_empty` rises in the same cycle that the held byte enters the shift register, which is the cycle the start bit begins. A later write while a frame is in progress waits in the holding register, and a further write before that byte is taken replaces it.
- R9: `tx_empty` is high only when the holding register is empty and the last stop bit has ended. A byte waiting at the end of a stop bit starts its start bit at once, with no idle gap.
- R10: Length, parity and stop settings are captured when a frame starts. Changes during the frame do not alter it.
- R11: After reset `txd` is high and `hold_empty` and `tx_empty` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 1 | Write address (0 or 1) |
| div_sel | input | 1 | 1: writes go to the divisor bytes, 0: to the holding register |
| wr_data | input | 8 | Write data byte |
| cfg_len | input | 2 | Data length code, length = 5 + code |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop_long | input | 1 | 0: one stop bit, 1: two stop bits (1.5 at five data bits) |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register empty and frame finished |

## Verification
The hardest situation to reach is the handover at the very end of a stop bit, where a waiting byte must start its frame with no idle gap. That same moment also decides whether `tx_empty` stays low. The bench writes a second byte while the first frame is in flight and then overwrites it. It checks cycle by cycle that the new start bit falls exactly one frame length after the first. It also checks that `tx_empty` never rises between the two frames and that only the last written byte is sent. The bench reaches the mid-frame configuration case by changing every framing input just after a start edge. It then decodes the frame and measures its length against the settings captured at the start.

// File: rtl/async_tx.sv
module async_tx #(
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic       div_sel,
  input  logic [7:0] wr_data,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop_long,
  output logic       txd,
  output logic       hold_empty,
  output logic       tx_empty
);

  localparam int TW = $clog2(2 * OVERSAMPLE);
  localparam logic [TW-1:0] BIT_LAST   = TW'(OVERSAMPLE - 1);
  localparam logic [TW-1:0] STOP1_LAST = TW'(OVERSAMPLE - 1);
  localparam logic [TW-1:0] STOPH_LAST = TW'(OVERSAMPLE * 3 / 2 - 1);
  localparam logic [TW-1:0] STOP2_LAST = TW'(2 * OVERSAMPLE - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} tx_state_t;

  logic [DIV_W-1:0] div_q, bcnt;
  logic [DIV_W:0]   bnext;
  logic             tick;

  tx_state_t  state;
  logic [TW-1:0] tcnt;
  logic [2:0]    bidx, f_last;
  logic [7:0]    shreg, hold_q;
  logic          f_par_en, f_par_bit;
  logic [TW-1:0] f_stop_last;

  logic       hold_wr, load, bit_end, stop_end;
  logic [7:0] len_mask;

  assign hold_wr  = wr_en && !div_sel && !wr_addr;
  assign bnext    = {1'b0, bcnt} + (DIV_W+1)'(1);
  assign tick     = bnext >= {1'b0, div_q};
  assign bit_end  = tcnt == BIT_LAST;
  assign stop_end = (state == S_STOP) && (tcnt == f_stop_last);
  assign load     = tick && !hold_empty && (state == S_IDLE || stop_end);
  assign len_mask = 8'hFF >> (2'd3 - cfg_len);
  assign tx_empty = hold_empty && (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(1);
      bcnt  <= '0;
    end else begin
      bcnt <= tick ? '0 : bnext[DIV_W-1:0];
      if (wr_en && div_sel) begin
        if (!wr_addr) div_q[7:0] <= wr_data;
        else          div_q[DIV_W-1:8] <= wr_data[DIV_W-9:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_empty <= 1'b1;
    end else begin
      if (hold_wr) begin
        hold_q     <= wr_data;
        hold_empty <= 1'b0;
      end else if (load) begin
        hold_empty <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tcnt        <= '0;
      bidx        <= '0;
      shreg       <= '0;
      f_last      <= '0;
      f_par_en    <= 1'b0;
      f_par_bit   <= 1'b0;
      f_stop_last <= STOP1_LAST;
      txd         <= 1'b1;
    end else if (load) begin
      state     <= S_START;
      tcnt      <= '0;
      bidx      <= '0;
      shreg     <= hold_q & len_mask;
      f_last    <= 3'd4 + {1'b0, cfg_len};
      f_par_en  <= cfg_par_en;
      f_par_bit <= (^(hold_q & len_mask)) ^ cfg_par_odd;
      if (!cfg_stop_long)      f_stop_last <= STOP1_LAST;
      else if (cfg_len == 2'd0) f_stop_last <= STOPH_LAST;
      else                      f_stop_last <= STOP2_LAST;
      txd <= 1'b0;
    end else if (tick) begin
      tcnt <= tcnt + TW'(1);
      unique case (state)
        S_START: if (bit_end) begin
          state <= S_DATA;
          tcnt  <= '0;
          txd   <= shreg[0];
        end
        S_DATA: if (bit_end) begin
          tcnt  <= '0;
          shreg <= shreg >> 1;
          if (bidx == f_last) begin
            state <= f_par_en ? S_PAR : S_STOP;
            txd   <= f_par_en ? f_par_bit : 1'b1;
          end else begin
            bidx <= bidx + 3'd1;
            txd  <= shreg[1];
          end
        end
        S_PAR: if (bit_end) begin
          state <= S_STOP;
          tcnt  <= '0;
          txd   <= 1'b1;
        end
        S_STOP: if (stop_end) begin
          state <= S_IDLE;
          tcnt  <= '0;
        end
        default: tcnt <= '0;
      endcase
    end
  end

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> txd);
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START) |-> !txd);
  a_r1_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP) |-> txd);
  a_r5_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tcnt));
  a_r4_stop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP) |-> (tcnt <= f_stop_last));
  a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> !hold_empty);
  a_r8_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !hold_wr) |=> (hold_empty && state == S_START));
  a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (txd && hold_empty));

endmodule

// File: tb/test_async_tx.sv
`timescale 1ns/1ps
module test_async_tx;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0, div_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop_long = 1'b0;
  logic txd, hold_empty, tx_empty;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_tx i_async_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .div_sel(div_sel),
    .wr_data(wr_data), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop_long(cfg_stop_long),
    .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty));

  // {div[15:0], len[1:0], par_en, par_odd, stop_long, data[7:0]}
  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {16'd1,   2'd3, 1'b0, 1'b0, 1'b0, 8'hA5},
    {16'd2,   2'd0, 1'b1, 1'b0, 1'b1, 8'hF3},
    {16'd3,   2'd1, 1'b1, 1'b1, 1'b1, 8'h2C},
    {16'd1,   2'd2, 1'b1, 1'b0, 1'b0, 8'h7F},
    {16'd0,   2'd3, 1'b1, 1'b1, 1'b0, 8'h00},
    {16'h0101,2'd0, 1'b0, 1'b0, 1'b0, 8'h0A},
    {16'd2,   2'd3, 1'b0, 1'b0, 1'b1, 8'h81},
    {16'd1,   2'd0, 1'b0, 1'b0, 1'b0, 8'h15}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic ds, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; div_sel = ds; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; div_sel = 1'b0; wr_addr = 1'b0;
  endtask

  function automatic logic [11:0] exp_frame(logic [7:0] d, int n, bit pe, bit po);
    logic [11:0] f = '0;
    logic p = po;
    for (int i = 0; i < n; i++) begin
      f[1+i] = d[i];
      p ^= d[i];
    end
    if (pe) f[1+n] = p;
    f[1+n+int'(pe)] = 1'b1;
    return f;
  endfunction

  function automatic int stop_ticks(int n, bit sl);
    return !sl ? 16 : (n == 5 ? 24 : 32);
  endfunction

  task automatic wait_fall(output int t0);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
  endtask

  // called at the negedge the start bit is first seen; returns at mid first stop
  task automatic capture(input int ed, input int n, input bit pe, output logic [11:0] obs);
    obs = '0;
    repeat (8*ed) @(negedge clk);
    obs[0] = txd;
    for (int i = 1; i < 2 + n + int'(pe); i++) begin
      repeat (16*ed) @(negedge clk);
      obs[i] = txd;
    end
  endtask

  task automatic wait_empty(output int t1);
    while (tx_empty !== 1'b1) @(negedge clk);
    t1 = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int t0, t1, n, ed, tick_cnt;
    bit seen_empty;
    logic [11:0] obs;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 txd", txd, 1);
    chk("R11 hold_empty", hold_empty, 1);
    chk("R11 tx_empty", tx_empty, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 default divisor is 1: 8N1 frame spans 160 cycles
    wr(1'b0, 1'b0, 8'h55);
    wait_fall(t0);
    capture(1, 8, 1'b0, obs);
    chk("R6 default divisor frame", obs, exp_frame(8'h55, 8, 0, 0));
    wait_empty(t1);
    chk("R6 default divisor length", t1 - t0, 160);

    // R7 write to address 1 with div_sel low changes nothing
    wr(1'b1, 1'b0, 8'hFF);
    seen_empty = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!(hold_empty && txd && tx_empty)) seen_empty = 1'b0;
    end
    chk("R7 ignored write", seen_empty, 1);

    // vector table: R1 R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      logic [15:0] dv;
      dv = VEC[v][28:13];
      cfg_len = VEC[v][12:11];
      cfg_par_en = VEC[v][10];
      cfg_par_odd = VEC[v][9];
      cfg_stop_long = VEC[v][8];
      n = 5 + int'(VEC[v][12:11]);
      ed = (dv == 0) ? 1 : int'(dv);
      wr(1'b0, 1'b1, dv[7:0]);
      wr(1'b1, 1'b1, dv[15:8]);
      wr(1'b0, 1'b0, VEC[v][7:0]);
      chk($sformatf("R7 hold_empty low after write v%0d", v), hold_empty, 0);
      wait_fall(t0);
      chk($sformatf("R8 hold_empty at start v%0d", v), hold_empty, 1);
      capture(ed, n, VEC[v][10], obs);
      chk($sformatf("R1 R2 R3 frame bits v%0d", v), obs,
          exp_frame(VEC[v][7:0], n, VEC[v][10], VEC[v][9]));
      wait_empty(t1);
      tick_cnt = 16*(1 + n + int'(VEC[v][10])) + stop_ticks(n, VEC[v][8]);
      chk($sformatf("R4 R5 frame length v%0d", v), t1 - t0, tick_cnt*ed);
    end

    // R8 R9 back-to-back with overwrite of the waiting byte
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop_long = 1'b0;
    wr(1'b0, 1'b1, 8'd1);
    wr(1'b1, 1'b1, 8'd0);
    wr(1'b0, 1'b0, 8'hFF);
    wait_fall(t0);
    wr(1'b0, 1'b0, 8'h11);
    chk("R8 second byte held", hold_empty, 0);
    wr(1'b0, 1'b0, 8'h3C);
    seen_empty = 1'b0;
    while (cyc - t0 < 159) begin
      @(negedge clk);
      if (tx_empty) seen_empty = 1'b1;
    end
    chk("R9 tx_empty stays low between frames", seen_empty, 0);
    chk("R9 stop still high before handover", txd, 1);
    @(negedge clk);
    chk("R9 next start with no gap", txd, 0);
    chk("R8 hold_empty at second start", hold_empty, 1);
    capture(1, 8, 1'b0, obs);
    chk("R8 overwritten byte sent", obs, exp_frame(8'h3C, 8, 0, 0));
    wait_empty(t1);
    chk("R9 tx_empty after last stop", t1 - t0, 320);

    // R10 configuration changes mid-frame are ignored
    wr(1'b0, 1'b1, 8'd2);
    wr(1'b0, 1'b0, 8'h96);
    wait_fall(t0);
    cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_stop_long = 1'b1;
    capture(2, 8, 1'b0, obs);
    chk("R10 frame bits keep start config", obs, exp_frame(8'h96, 8, 0, 0));
    wait_empty(t1);
    chk("R10 frame length keeps start config", t1 - t0, 320);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule